// File: doc/BRIEF.md
# Graphics pixel address generator

This block turns a pixel coordinate into a location in video memory for a 2D drawing engine. A request carries an 11-bit column and an 11-bit row, and uses a valid/ready handshake. The configuration travels with each request: row width, pixel depth, memory data bus width and a 12-bit base that supplies the top address bits. For each accepted request the block returns one response. The response carries a 32-bit byte address, the bus-word address and byte lane for the chosen bus width, and the bit offset of the pixel within its byte.

Power-of-two row widths turn the row number into a row offset with a fixed shift. These requests complete in one cycle, and a new request can be accepted every cycle. A 320-pixel row width serves panels that do not fit a power-of-two page. It builds the row offset from two partial products over two cycles, and the input handshake stalls for one cycle while it does so. Requests that are out of range, or that use an illegal combination of settings, return an error response and leave the address outputs unchanged.

Top module: `pix_addr_gen`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` and `rspError` are 0, and every address output is 0.
- R2: Row codes 0, 1, 2 and 3 select row widths of 256, 512, 1024 and 2048 pixels, with pixel index = y × width + x. A valid request under one of these codes gives `rspValid` one cycle after acceptance, and `reqReady` stays 1.
- R3: Row code 4 selects a 320-pixel row. An accepted request under this code drops `reqReady` for the next cycle, and `rspValid` rises two cycles after acceptance.
- R4: Depth codes 0 to 5 select 1, 2, 4, 8, 16 and 24 bits per pixel. The byte offset is floor(index × bpp / 8), and `rspBitOff` is (index × bpp) mod 8.
- R5: `rspByteAddr` equals (base × 2^20 + byte offset) mod 2^32.
- R6: Bus codes 0, 1 and 2 select 8-, 16- and 32-bit buses. `rspWordAddr` is `rspByteAddr` shifted right by 0, 1 or 2, and `rspLane` is the low 0, 1 or 2 bits of `rspByteAddr`.
- R7: A request is an error if any of these holds: x is at or beyond the row width; row code 4 is used with a depth code other than 3; or a code is unassigned (row above 4, depth above 5, bus code 3). An error gives `rspValid` and `rspError` one cycle after acceptance, and all address outputs keep their previous values.
- R8: The configuration and the coordinate are captured at acceptance. Changing them while a 320-row request is still being computed does not change its result.
- R9: `rspValid` is high for exactly one cycle for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqX | input | 11 | Pixel column |
| reqY | input | 11 | Pixel row |
| cfgRowSel | input | 3 | Row width code |
| cfgDepthSel | input | 3 | Pixel depth code |
| cfgBusSel | input | 2 | Memory bus width code |
| cfgBase | input | 12 | Upper address bits 31:20 |
| rspValid | output | 1 | Response pulse |
| rspError | output | 1 | Response is an error |
| rspByteAddr | output | 32 | Byte address of the pixel |
| rspWordAddr | output | 32 | Bus-word address |
| rspLane | output | 2 | Byte lane within the bus word |
| rspBitOff | output | 3 | Bit offset within the byte |

## Verification
The bench targets these corner cases:
- The last column of each row width, including x = 319 and x = 320 in the 320-pixel mode. A wrong limit would either reject a legal pixel or produce an address that spills into the next row.
- Full-page coordinates at 24 bpp combined with base 0xFFF. These check the carry into the top bits and the wrap modulo 2^32. A truncated sum would give an address far from the expected one.
- The configuration inputs are scrambled during the 320-pixel mode's second cycle. A design that does not sample at acceptance would return an address built from the new values.
- Each error case is checked to confirm that the previous address is still held. A design that updates on an error would overwrite it.

// File: rtl/pix_addr_pkg.sv
package pix_addr_pkg;
  localparam int CoordW = 11;
  localparam int BaseW  = 12;
  localparam int AddrW  = 32;
  localparam int RowW   = 2 * CoordW;          // row offset width
  localparam int IdxW   = RowW + 1;            // pixel index width
  localparam int ProdW  = IdxW + 5;            // index times bpp
  localparam int LowW   = AddrW - BaseW;       // bits below the base field
  localparam logic [2:0] RowCode320 = 3'd4;
  localparam logic [2:0] Depth8Code = 3'd3;

  typedef struct packed {
    logic [2:0]       rowSel;
    logic [2:0]       depthSel;
    logic [1:0]       busSel;
    logic [BaseW-1:0] base;
  } pix_cfg_t;

  typedef struct packed {
    logic fastDone;
    logic slowLoad;
    logic slowDone;
    logic errDone;
  } ctrl_strobe_t;
endpackage

// File: rtl/pix_addr_ctrl.sv
module pix_addr_ctrl
  import pix_addr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqBad,
  input  logic         reqSlow,
  output logic         reqReady,
  output ctrl_strobe_t strobe
);
  typedef enum logic {ST_IDLE, ST_SLOW} state_t;
  state_t state;
  logic accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid & reqReady;

  always_comb begin
    strobe          = '0;
    strobe.errDone  = accept & reqBad;
    strobe.fastDone = accept & ~reqBad & ~reqSlow;
    strobe.slowLoad = accept & ~reqBad & reqSlow;
    strobe.slowDone = (state == ST_SLOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else if (strobe.slowLoad) state <= ST_SLOW;
    else if (state == ST_SLOW) state <= ST_IDLE;
  end

  AST_SLOW_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (accept && reqSlow && !reqBad) |=> !reqReady) else $error("stall missing"); // R3
endmodule

// File: rtl/pix_addr_dp.sv
module pix_addr_dp
  import pix_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CoordW-1:0] inX,
  input  logic [CoordW-1:0] inY,
  input  pix_cfg_t          inCfg,
  input  ctrl_strobe_t      strobe,
  output logic              reqBad,
  output logic              reqSlow,
  output logic              rspValid,
  output logic              rspError,
  output logic [AddrW-1:0]  rspByteAddr,
  output logic [AddrW-1:0]  rspWordAddr,
  output logic [1:0]        rspLane,
  output logic [2:0]        rspBitOff
);
  // request checking
  logic [CoordW:0] rowLimit;
  always_comb begin
    case (inCfg.rowSel)
      3'd0:    rowLimit = 12'd256;
      3'd1:    rowLimit = 12'd512;
      3'd2:    rowLimit = 12'd1024;
      3'd3:    rowLimit = 12'd2048;
      default: rowLimit = 12'd320;
    endcase
  end

  assign reqSlow = (inCfg.rowSel == RowCode320);
  assign reqBad  = (inCfg.rowSel > RowCode320) || (inCfg.depthSel > 3'd5) ||
                   (inCfg.busSel == 2'd3) ||
                   (reqSlow && inCfg.depthSel != Depth8Code) ||
                   ({1'b0, inX} >= rowLimit);

  // power-of-two row offset: a fixed shift
  logic [RowW-1:0] rowFast;
  assign rowFast = RowW'(inY) << (8 + inCfg.rowSel[1:0]);

  // 320-pixel row offset over two cycles
  logic [CoordW-1:0] holdX, holdY;
  pix_cfg_t          holdCfg;
  logic [RowW-1:0]   partRow, rowSlow;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdX <= '0; holdY <= '0; holdCfg <= '0; partRow <= '0;
    end else if (strobe.slowLoad) begin
      holdX   <= inX;
      holdY   <= inY;
      holdCfg <= inCfg;
      partRow <= RowW'(inY) << 8;
    end
  end
  assign rowSlow = partRow + (RowW'(holdY) << 6);

  // finalize
  logic [RowW-1:0]   selRow;
  logic [CoordW-1:0] selX;
  pix_cfg_t          selCfg;
  logic [4:0]        bpp;
  logic [IdxW-1:0]   pixIdx;
  logic [ProdW-1:0]  bitPos;
  logic [AddrW-1:0]  byteAddr, wordAddr;
  logic [1:0]        lane;

  assign selRow = strobe.slowDone ? rowSlow : rowFast;
  assign selX   = strobe.slowDone ? holdX   : inX;
  assign selCfg = strobe.slowDone ? holdCfg : inCfg;

  always_comb begin
    case (selCfg.depthSel)
      3'd0:    bpp = 5'd1;
      3'd1:    bpp = 5'd2;
      3'd2:    bpp = 5'd4;
      3'd3:    bpp = 5'd8;
      3'd4:    bpp = 5'd16;
      default: bpp = 5'd24;
    endcase
  end

  assign pixIdx   = IdxW'(selRow) + IdxW'(selX);
  assign bitPos   = ProdW'(pixIdx) * ProdW'(bpp);
  assign byteAddr = {selCfg.base, {LowW{1'b0}}} + AddrW'(bitPos[ProdW-1:3]);

  always_comb begin
    case (selCfg.busSel)
      2'd0:    begin wordAddr = byteAddr;      lane = 2'd0;                end
      2'd1:    begin wordAddr = byteAddr >> 1; lane = {1'b0, byteAddr[0]}; end
      default: begin wordAddr = byteAddr >> 2; lane = byteAddr[1:0];       end
    endcase
  end

  // response registers
  logic doneAny;
  assign doneAny = strobe.fastDone | strobe.slowDone;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0; rspError <= 1'b0;
      rspByteAddr <= '0; rspWordAddr <= '0; rspLane <= '0; rspBitOff <= '0;
    end else begin
      rspValid <= doneAny | strobe.errDone;
      rspError <= strobe.errDone;
      if (doneAny) begin
        rspByteAddr <= byteAddr;
        rspWordAddr <= wordAddr;
        rspLane     <= lane;
        rspBitOff   <= bitPos[2:0];
      end
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> ($stable(rspByteAddr) && $stable(rspWordAddr))) else $error("error moved address"); // R7
endmodule

// File: rtl/pix_addr_gen.sv
module pix_addr_gen
  import pix_addr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [CoordW-1:0] reqX,
  input  logic [CoordW-1:0] reqY,
  input  logic [2:0]        cfgRowSel,
  input  logic [2:0]        cfgDepthSel,
  input  logic [1:0]        cfgBusSel,
  input  logic [BaseW-1:0]  cfgBase,
  output logic              rspValid,
  output logic              rspError,
  output logic [AddrW-1:0]  rspByteAddr,
  output logic [AddrW-1:0]  rspWordAddr,
  output logic [1:0]        rspLane,
  output logic [2:0]        rspBitOff
);
  pix_cfg_t     cfg;
  ctrl_strobe_t strobe;
  logic         reqBad, reqSlow;

  assign cfg = '{rowSel: cfgRowSel, depthSel: cfgDepthSel, busSel: cfgBusSel, base: cfgBase};

  pix_addr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBad(reqBad),
    .reqSlow(reqSlow), .reqReady(reqReady), .strobe(strobe)
  );

  pix_addr_dp u_dp (
    .clk(clk), .rstN(rstN), .inX(reqX), .inY(reqY), .inCfg(cfg), .strobe(strobe),
    .reqBad(reqBad), .reqSlow(reqSlow), .rspValid(rspValid), .rspError(rspError),
    .rspByteAddr(rspByteAddr), .rspWordAddr(rspWordAddr), .rspLane(rspLane),
    .rspBitOff(rspBitOff)
  );

  logic acceptTop;
  assign acceptTop = reqValid & reqReady;

  AST_FAST_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (acceptTop && !reqSlow && !reqBad) |=> (rspValid && !rspError && reqReady)) else $error("fast response late"); // R2
  AST_SLOW_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (acceptTop && reqSlow && !reqBad) |=> (!rspValid ##1 (rspValid && !rspError))) else $error("slow response timing"); // R3
  AST_ERR_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (acceptTop && reqBad) |=> (rspValid && rspError)) else $error("error response missing"); // R7
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !$past(acceptTop)) |-> $past(!reqReady)) else $error("stray response"); // R9
endmodule

// File: tb/sim_pix_addr_gen.sv
module sim_pix_addr_gen;
  localparam int ClkPeriod = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [10:0] reqX = '0, reqY = '0;
  logic [2:0] cfgRowSel = '0, cfgDepthSel = '0;
  logic [1:0] cfgBusSel = '0;
  logic [11:0] cfgBase = '0;
  logic rspValid, rspError;
  logic [31:0] rspByteAddr, rspWordAddr;
  logic [1:0] rspLane;
  logic [2:0] rspBitOff;

  int nVec = 0, nBad = 0;
  logic [31:0] lastByte = '0, lastWord = '0;

  always #(ClkPeriod/2) clk = ~clk;

  pix_addr_gen u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runReq(int x, int y, int row, int dep, int bus, int base);
    longint rs, bpp, idx, bits, eb, ew, el;
    bit err;
    rs = (row < 4) ? (256 << row) : 320;
    case (dep) 0: bpp = 1; 1: bpp = 2; 2: bpp = 4; 3: bpp = 8; 4: bpp = 16; default: bpp = 24; endcase
    err = (row > 4) || (dep > 5) || (bus == 3) || (row == 4 && dep != 3) || (x >= rs);
    idx  = y * rs + x;
    bits = idx * bpp;
    eb   = ((longint'(base) << 20) + (bits >> 3)) & 64'hFFFF_FFFF;
    ew   = eb >> bus;
    el   = eb & ((64'd1 << bus) - 1);
    @(negedge clk);
    chk("R2 ready before request", 32'(reqReady), 32'd1);
    reqValid = 1'b1; reqX = 11'(x); reqY = 11'(y);
    cfgRowSel = 3'(row); cfgDepthSel = 3'(dep); cfgBusSel = 2'(bus); cfgBase = 12'(base);
    @(negedge clk);
    reqValid = 1'b0; reqX = ~reqX; reqY = ~reqY;          // R8 scramble
    cfgBase = ~cfgBase; cfgBusSel = 2'($urandom % 3); cfgDepthSel = 3'($urandom % 6);
    if (err) begin
      chk("R7 error valid", 32'(rspValid), 32'd1);
      chk("R7 error flag", 32'(rspError), 32'd1);
      chk("R7 byte held", rspByteAddr, lastByte);
      chk("R7 word held", rspWordAddr, lastWord);
    end else begin
      if (row == 4) begin
        chk("R3 no early response", 32'(rspValid), 32'd0);
        chk("R3 ready low", 32'(reqReady), 32'd0);
        @(negedge clk);
        chk("R3 slow valid", 32'(rspValid), 32'd1);
      end else begin
        chk("R2 fast valid", 32'(rspValid), 32'd1);
        chk("R2 ready high", 32'(reqReady), 32'd1);
      end
      chk("R7 no error", 32'(rspError), 32'd0);
      chk("R5 R8 byte address", rspByteAddr, 32'(eb));
      chk("R4 bit offset", 32'(rspBitOff), 32'(bits & 7));
      chk("R6 word address", rspWordAddr, 32'(ew));
      chk("R6 lane", 32'(rspLane), 32'(el));
      lastByte = 32'(eb); lastWord = 32'(ew);
    end
    @(negedge clk);
    chk("R9 single pulse", 32'(rspValid), 32'd0);
  endtask

  initial begin
    #(ClkPeriod * 150000);
    nBad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", 32'(reqReady), 32'd1);
    chk("R1 valid", 32'(rspValid), 32'd0);
    chk("R1 error", 32'(rspError), 32'd0);
    chk("R1 byte", rspByteAddr, 32'd0);
    chk("R1 word", rspWordAddr, 32'd0);
    // directed corners
    runReq(2047, 2047, 3, 5, 2, 12'hFFF);   // full page, wrap past 2^32
    runReq(255, 1, 0, 0, 0, 0);             // last column, 1 bpp
    runReq(256, 1, 0, 3, 0, 0);             // R7 x beyond row
    runReq(319, 239, 4, 3, 1, 12'h123);     // 320 mode last column
    runReq(320, 5, 4, 3, 1, 0);             // R7 320 mode overflow
    runReq(10, 10, 4, 4, 2, 0);             // R7 320 mode wrong depth
    runReq(3, 3, 5, 3, 0, 0);               // R7 unassigned row code
    runReq(3, 3, 1, 6, 0, 0);               // R7 unassigned depth code
    runReq(3, 3, 1, 3, 3, 0);               // R7 unassigned bus code
    runReq(7, 0, 2, 1, 1, 12'h800);         // 2 bpp bit offset
    runReq(5, 1023, 2, 2, 2, 12'h001);      // 4 bpp
    // constrained random
    for (int i = 0; i < 400; i++) begin
      int row, dep, bus, x, y, rs;
      row = $urandom % 5;
      dep = (row == 4) ? (($urandom % 8 == 0) ? $urandom % 6 : 3) : $urandom % 6;
      bus = $urandom % 3;
      if ($urandom % 25 == 0) row = 5 + $urandom % 3;
      rs = (row < 4) ? (256 << row) : 320;
      x = ($urandom % 8 == 0) ? $urandom % 2048 : $urandom % rs;
      y = $urandom % 2048;
      runReq(x, y, row, dep, bus, $urandom % 4096);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule